// File: doc/BRIEF.md
# Resizer Configuration Calculator

This unit turns a source frame size and a target frame size into the settings that a two-axis video resizer needs. It decides whether the resizer can be bypassed. It chooses a horizontal pre-decimation factor and picks the vertical filter type: polyphase, or running average for strong vertical shrinks. It then computes fixed-point step values for each axis. For the running-average filter it also computes a weight and two initial accumulator values.

A caller places the four dimensions on the inputs and pulses `start`. The unit captures the dimensions on that edge, so the inputs may change afterwards. It runs its sequence and raises `done` for exactly one cycle. The results stay on the outputs until the next accepted start. Every quotient comes from one shared restoring divider that produces one quotient bit per cycle.

The controller has six named states:
- `ST_IDLE`: waits for `start`. It goes to `ST_DECIDE` when `start` is high.
- `ST_DECIDE`: registers the mode flags. It goes to `ST_FINISH` on bypass. Otherwise it launches the horizontal division and goes to `ST_HDIV`.
- `ST_HDIV`: waits for the divider. When the divider finishes, it stores the horizontal step, launches the vertical division and goes to `ST_VDIV`.
- `ST_VDIV`: stores the vertical quotient when the divider finishes. It then goes to `ST_RAVINIT` in running-average mode, or to `ST_FINISH` otherwise.
- `ST_RAVINIT`: stores both initial values and goes to `ST_FINISH`.
- `ST_FINISH`: drives `done` and returns to `ST_IDLE`.

Top module: `rsz_cfg_calc`

## Requirements
- R1: When source width equals target width and source height equals target height, `bypass` is 1. In that case `linear`, `dcm2x`, `dcm4x` and `rav_sel` are 0, and every numeric output is 0.
- R2: In every case that is not bypass, `linear` is 1.
- R3: Let q = floor(src_w / dst_w). If q > 4, then `dcm4x`=1 and the width is shifted right by 2. Else if q > 2, then `dcm2x`=1 and the width is shifted right by 1. Otherwise neither flag is set and there is no shift. The two flags are never both 1.
- R4: `h_step` = (((src_w >> shift) - 1) << 24) / (dst_w - 1). This is unsigned division, and the result keeps its low 32 bits.
- R5: `rav_sel` is 1 exactly when the case is not bypass and dst_h < (src_h >> 2).
- R6: In running-average mode, `rav_weight` = (dst_h << 10) / src_h, and the result keeps its low 16 bits.
- R7: Let w be the weight. Then `rav_init_a` = w + ((1 + w) >> 1), minus 1024 when that sum is 1024 or more.
- R8: Let a be the value from R7. Compute b = a + 1 + (a >> 1) - 512. If b is negative, b becomes b + a and `rav_init_a` becomes 2a. `rav_init_b` carries b as 16-bit two's complement.
- R9: In polyphase mode, `v_step` = ((src_h - 1) << 16) / (dst_h - 1), and the result keeps its low 32 bits.
- R10: Outputs that belong to the vertical mode not selected read 0. This means `v_step` in running-average mode, and the weight and both initial values in polyphase mode.
- R11: A division by zero does not hang the unit. The quotient saturates to all ones and is then cut to the field width. For example, dst_w = 1 gives `h_step` = 0xFFFFFFFF.
- R12: `done` is high for one cycle. It rises this many clock edges after the edge that accepted `start`:
  - 1 edge for bypass.
  - Otherwise, 1 edge plus, for each of the two divisions, 37 edges (1 edge if its divisor is 0), plus 1 edge in running-average mode.
  - With default parameters, polyphase takes 75 edges and running average takes 76.
  
  Results then hold until the next accepted start.
- R13: `start` is only accepted in `ST_IDLE`. A pulse during a computation changes neither its results nor its latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| src_w | input | DIM_W | Source width |
| src_h | input | DIM_W | Source height |
| dst_w | input | DIM_W | Target width |
| dst_h | input | DIM_W | Target height |
| done | output | 1 | One-cycle completion pulse |
| bypass | output | 1 | Sizes match, resizer bypassed |
| linear | output | 1 | Linear scaling enabled |
| dcm2x | output | 1 | Horizontal 2x pre-decimation |
| dcm4x | output | 1 | Horizontal 4x pre-decimation |
| rav_sel | output | 1 | Vertical running-average filter selected |
| h_step | output | 32 | Horizontal step, 24 fraction bits |
| v_step | output | 32 | Vertical polyphase step, 16 fraction bits |
| rav_weight | output | 16 | Running-average weight, 10 fraction bits |
| rav_init_a | output | 16 | First running-average initial value |
| rav_init_b | output | 16 | Second running-average initial value (two's complement) |

## Verification
The results appear at different times:
- The mode flags settle one edge after the start is accepted.
- `h_step` settles when the first division completes.
- The vertical result settles when the second division completes.
- The initial values settle one edge later.

None of these intermediate moments is sampled. The bench counts the clock edges from the accepted start until `done` is seen at a falling edge. It compares that count with the R12 formula for the vector, and it reads every result in that same `done` cycle. It also re-reads the results a few cycles later to confirm they hold. Running average is one edge slower than polyphase, and a zero divisor shortens its division to a single edge. Both effects are checked through the edge count.

// File: rtl/rsz_cfg_pkg.sv
package rsz_cfg_pkg;
    localparam int H_FRAC = 24;
    localparam int V_FRAC = 16;
    localparam int W_FRAC = 10;
    localparam int STEP_W = 32;
    localparam int WGT_W  = 16;
    localparam int INIT_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_HDIV,
        ST_VDIV,
        ST_RAVINIT,
        ST_FINISH
    } state_t;
endpackage

// File: rtl/rsz_div.sv
module rsz_div #(
    parameter int NUM_W = 36,
    parameter int DEN_W = 12,
    parameter int QUO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [QUO_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] q_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [DEN_W:0]   trial;
    logic             ge;
    logic [DEN_W:0]   diff;

    always_comb begin
        trial = {rem_q, q_q[NUM_W-1]};
        ge    = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            q_q    <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (go) begin
            busy_q <= 1'b1;
            rem_q  <= '0;
            den_q  <= den;
            if (den == '0) begin
                q_q   <= '1;
                cnt_q <= '0;
            end else begin
                q_q   <= num;
                cnt_q <= CNT_W'(NUM_W);
            end
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                q_q   <= {q_q[NUM_W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign fin = busy_q && (cnt_q == '0);
    assign quo = q_q[QUO_W-1:0];
endmodule

// File: rtl/rsz_rav_init.sv
module rsz_rav_init
    import rsz_cfg_pkg::*;
(
    input  logic [WGT_W-1:0]  wgt,
    output logic [INIT_W-1:0] init_a,
    output logic [INIT_W-1:0] init_b
);
    localparam int AW = WGT_W + 4;
    localparam logic signed [AW-1:0] FULL = AW'(1 << W_FRAC);
    localparam logic signed [AW-1:0] HALF = AW'(1 << (W_FRAC - 1));
    localparam logic signed [AW-1:0] ONE  = AW'(1);

    logic signed [AW-1:0] w_s, a0, a1, b0, a_fin, b_fin;

    always_comb begin
        w_s = {{(AW-WGT_W){1'b0}}, wgt};
        a0  = w_s + ((w_s + ONE) >>> 1);
        a1  = (a0 >= FULL) ? a0 - FULL : a0;
        b0  = a1 + ONE + (a1 >>> 1) - HALF;
        if (b0 < 0) begin
            b_fin = b0 + a1;
            a_fin = a1 <<< 1;
        end else begin
            b_fin = b0;
            a_fin = a1;
        end
        init_a = a_fin[INIT_W-1:0];
        init_b = b_fin[INIT_W-1:0];
    end
endmodule

// File: rtl/rsz_cfg_calc.sv
module rsz_cfg_calc
    import rsz_cfg_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  src_w,
    input  logic [DIM_W-1:0]  src_h,
    input  logic [DIM_W-1:0]  dst_w,
    input  logic [DIM_W-1:0]  dst_h,
    output logic              done,
    output logic              bypass,
    output logic              linear,
    output logic              dcm2x,
    output logic              dcm4x,
    output logic              rav_sel,
    output logic [STEP_W-1:0] h_step,
    output logic [STEP_W-1:0] v_step,
    output logic [WGT_W-1:0]  rav_weight,
    output logic [INIT_W-1:0] rav_init_a,
    output logic [INIT_W-1:0] rav_init_b
);
    localparam int NUM_W = DIM_W + H_FRAC;
    localparam int RW    = DIM_W + 3;

    state_t state_q, state_nxt;

    logic [DIM_W-1:0]  sw_q, sh_q, dw_q, dh_q;
    logic              byp_q, lin_q, d2_q, d4_q, rav_q;
    logic [STEP_W-1:0] hq_q, vq_q;
    logic [INIT_W-1:0] ia_q, ib_q;

    logic              is_byp, dec4, dec2, rav_pick;
    logic [RW-1:0]     sw_x, dw_x3, dw_x5;
    logic [DIM_W-1:0]  h_src;
    logic [NUM_W-1:0]  h_num, v_num, w_num;
    logic              div_go;
    logic [NUM_W-1:0]  div_num;
    logic [DIM_W-1:0]  div_den;
    logic              div_fin;
    logic [STEP_W-1:0] div_quo;
    logic [INIT_W-1:0] ia_c, ib_c;

    // Ratio tests on the captured sizes
    always_comb begin
        is_byp   = (sw_q == dw_q) && (sh_q == dh_q);
        sw_x     = {3'b000, sw_q};
        dw_x3    = ({3'b000, dw_q} << 1) + {3'b000, dw_q};
        dw_x5    = ({3'b000, dw_q} << 2) + {3'b000, dw_q};
        dec4     = sw_x >= dw_x5;
        dec2     = sw_x >= dw_x3;
        rav_pick = dh_q < (sh_q >> 2);
        h_src    = dec4 ? (sw_q >> 2) : (dec2 ? (sw_q >> 1) : sw_q);
        h_num    = {h_src - DIM_W'(1), {H_FRAC{1'b0}}};
        v_num    = {{(NUM_W-DIM_W-V_FRAC){1'b0}}, sh_q - DIM_W'(1), {V_FRAC{1'b0}}};
        w_num    = {{(NUM_W-DIM_W-W_FRAC){1'b0}}, dh_q, {W_FRAC{1'b0}}};
    end

    // Next state and divider launch
    always_comb begin
        state_nxt = state_q;
        div_go    = 1'b0;
        div_num   = h_num;
        div_den   = dw_q - DIM_W'(1);
        unique case (state_q)
            ST_IDLE:    if (start) state_nxt = ST_DECIDE;
            ST_DECIDE: begin
                if (is_byp) begin
                    state_nxt = ST_FINISH;
                end else begin
                    div_go    = 1'b1;
                    state_nxt = ST_HDIV;
                end
            end
            ST_HDIV: begin
                if (div_fin) begin
                    div_go    = 1'b1;
                    div_num   = rav_q ? w_num : v_num;
                    div_den   = rav_q ? sh_q : dh_q - DIM_W'(1);
                    state_nxt = ST_VDIV;
                end
            end
            ST_VDIV:    if (div_fin) state_nxt = rav_q ? ST_RAVINIT : ST_FINISH;
            ST_RAVINIT: state_nxt = ST_FINISH;
            ST_FINISH:  state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Captured operands and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '0; sh_q <= '0; dw_q <= '0; dh_q <= '0;
            byp_q <= 1'b0; lin_q <= 1'b0; d2_q <= 1'b0; d4_q <= 1'b0; rav_q <= 1'b0;
            hq_q <= '0; vq_q <= '0; ia_q <= '0; ib_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sw_q <= src_w; sh_q <= src_h;
                        dw_q <= dst_w; dh_q <= dst_h;
                    end
                end
                ST_DECIDE: begin
                    byp_q <= is_byp;
                    lin_q <= !is_byp;
                    d4_q  <= !is_byp && dec4;
                    d2_q  <= !is_byp && !dec4 && dec2;
                    rav_q <= !is_byp && rav_pick;
                    hq_q  <= '0; vq_q <= '0; ia_q <= '0; ib_q <= '0;
                end
                ST_HDIV:    if (div_fin) hq_q <= div_quo;
                ST_VDIV:    if (div_fin) vq_q <= div_quo;
                ST_RAVINIT: begin
                    ia_q <= ia_c;
                    ib_q <= ib_c;
                end
                ST_FINISH: begin end
                default:   begin end
            endcase
        end
    end

    rsz_div #(
        .NUM_W (NUM_W),
        .DEN_W (DIM_W),
        .QUO_W (STEP_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .fin   (div_fin),
        .quo   (div_quo)
    );

    rsz_rav_init u_init (
        .wgt    (vq_q[WGT_W-1:0]),
        .init_a (ia_c),
        .init_b (ib_c)
    );

    assign done       = (state_q == ST_FINISH);
    assign bypass     = byp_q;
    assign linear     = lin_q;
    assign dcm2x      = d2_q;
    assign dcm4x      = d4_q;
    assign rav_sel    = rav_q;
    assign h_step     = hq_q;
    assign v_step     = rav_q ? '0 : vq_q;
    assign rav_weight = rav_q ? vq_q[WGT_W-1:0] : '0;
    assign rav_init_a = ia_q;
    assign rav_init_b = ib_q;
endmodule

// File: rtl/rsz_cfg_calc_chk.sv
module rsz_cfg_calc_chk
    import rsz_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              bypass,
    input logic              linear,
    input logic              dcm2x,
    input logic              dcm4x,
    input logic              rav_sel,
    input logic [STEP_W-1:0] h_step,
    input logic [STEP_W-1:0] v_step,
    input logic [WGT_W-1:0]  rav_weight,
    input logic [INIT_W-1:0] rav_init_a,
    input logic [INIT_W-1:0] rav_init_b
);
    AST_BYPASS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        done && bypass |-> !linear && !dcm2x && !dcm4x && !rav_sel && h_step == '0
                            && v_step == '0 && rav_weight == '0 && rav_init_a == '0
                            && rav_init_b == '0); // R1
    AST_LINEAR_ON: assert property (@(posedge clk) disable iff (!rst_n)
        done && !bypass |-> linear); // R2
    AST_DCM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dcm2x, dcm4x})); // R3
    AST_RAV_NO_VSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        done && rav_sel |-> v_step == '0); // R10
    AST_POLY_NO_RAV: assert property (@(posedge clk) disable iff (!rst_n)
        done && !rav_sel |-> rav_weight == '0 && rav_init_a == '0 && rav_init_b == '0); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(h_step) && $stable(v_step) && $stable(rav_weight)
                 && $stable(rav_init_a) && $stable(rav_init_b) && $stable(bypass)); // R12
endmodule

bind rsz_cfg_calc rsz_cfg_calc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .bypass     (bypass),
    .linear     (linear),
    .dcm2x      (dcm2x),
    .dcm4x      (dcm4x),
    .rav_sel    (rav_sel),
    .h_step     (h_step),
    .v_step     (v_step),
    .rav_weight (rav_weight),
    .rav_init_a (rav_init_a),
    .rav_init_b (rav_init_b)
);

// File: tb/rsz_cfg_calc_test.sv
module rsz_cfg_calc_test;
    import rsz_cfg_pkg::*;

    localparam int DIM_W = 12;
    localparam int DIVC  = DIM_W + H_FRAC + 1;
    localparam int NVEC  = 13;
    // src_w, src_h, dst_w, dst_h
    localparam int VEC [NVEC][4] = '{
        '{640, 480, 640, 480},     // bypass
        '{1920, 1080, 1280, 720},  // mild shrink, no decimation
        '{720, 480, 1920, 1080},   // upscale
        '{1920, 1080, 640, 360},   // ratio 3 -> 2x
        '{1920, 1080, 320, 200},   // ratio 6 -> 4x, running average
        '{1280, 720, 640, 720},    // ratio 2 boundary, height equal
        '{1500, 1000, 500, 100},   // ratio exactly 3
        '{2000, 1000, 500, 250},   // ratio exactly 4, height on the rav boundary
        '{2500, 1000, 500, 249},   // ratio exactly 5, just inside rav
        '{640, 480, 1, 120},       // zero horizontal divisor
        '{8, 4, 5, 1},             // zero vertical divisor
        '{4095, 4095, 2, 3},       // step overflow, negative second init
        '{640, 480, 640, 240}      // width equal only
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DIM_W-1:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
    logic done, bypass, linear, dcm2x, dcm4x, rav_sel;
    logic [STEP_W-1:0] h_step, v_step;
    logic [WGT_W-1:0]  rav_weight;
    logic [INIT_W-1:0] rav_init_a, rav_init_b;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    rsz_cfg_calc #(.DIM_W(DIM_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .done(done), .bypass(bypass), .linear(linear), .dcm2x(dcm2x), .dcm4x(dcm4x),
        .rav_sel(rav_sel), .h_step(h_step), .v_step(v_step), .rav_weight(rav_weight),
        .rav_init_a(rav_init_a), .rav_init_b(rav_init_b)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected values from the requirements
    task automatic model(input longint sw, input longint sh, input longint dw, input longint dh,
                         output longint e[10], output int lat);
        longint q, sft, num, den, w, a, b;
        bit byp, rav;
        for (int i = 0; i < 10; i++) e[i] = 0;
        byp = (sw == dw) && (sh == dh);
        e[0] = byp;
        lat = 1;
        if (!byp) begin
            e[1] = 1;
            q = sw / dw;
            sft = (q > 4) ? 2 : ((q > 2) ? 1 : 0);
            e[2] = (sft == 1);
            e[3] = (sft == 2);
            num = ((sw >> sft) - 1) << H_FRAC;
            den = dw - 1;
            e[5] = (den == 0) ? 64'hFFFF_FFFF : ((num / den) & 64'hFFFF_FFFF);
            lat += (den == 0) ? 1 : DIVC;
            rav = dh < (sh >> 2);
            e[4] = rav;
            if (rav) begin
                w = ((dh << W_FRAC) / sh) & 64'hFFFF;
                a = w + ((1 + w) >> 1);
                if (a >= 1024) a -= 1024;
                b = a + (1 + (a >> 1)) - 512;
                if (b < 0) begin
                    b += a;
                    a *= 2;
                end
                e[7] = w;
                e[8] = a & 64'hFFFF;
                e[9] = b & 64'hFFFF;
                lat += DIVC + 1;
            end else begin
                den = dh - 1;
                e[6] = (den == 0) ? 64'hFFFF_FFFF : ((((sh - 1) << V_FRAC) / den) & 64'hFFFF_FFFF);
                lat += (den == 0) ? 1 : DIVC;
            end
        end
    endtask

    task automatic compare(input longint e[10], input bit rav, input bit hzero);
        chk("R1", "bypass", bypass, e[0]);
        chk("R2", "linear", linear, e[1]);
        chk("R3", "dcm2x", dcm2x, e[2]);
        chk("R3", "dcm4x", dcm4x, e[3]);
        chk("R5", "rav_sel", rav_sel, e[4]);
        chk(hzero ? "R11" : "R4", "h_step", h_step, e[5]);
        chk(rav ? "R10" : "R9", "v_step", v_step, e[6]);
        chk(rav ? "R6" : "R10", "rav_weight", rav_weight, e[7]);
        chk(rav ? "R7" : "R10", "rav_init_a", rav_init_a, e[8]);
        chk(rav ? "R8" : "R10", "rav_init_b", rav_init_b, e[9]);
    endtask

    // Start one computation; optionally pulse start again mid-run with other sizes
    task automatic run(input int sw, input int sh, input int dw, input int dh, input bit inject);
        longint e[10];
        int lat, n;
        model(sw, sh, dw, dh, e, lat);
        @(negedge clk);
        src_w = DIM_W'(sw); src_h = DIM_W'(sh); dst_w = DIM_W'(dw); dst_h = DIM_W'(dh);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        src_w = '0; src_h = '0; dst_w = '0; dst_h = '0;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 5) begin
                src_w = 12'd100; src_h = 12'd100; dst_w = 12'd100; dst_h = 12'd100;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end while (!done && n < 500);
        start = 1'b0;
        chk(inject ? "R13" : "R12", "latency", n, lat);
        compare(e, e[4] != 0, dw == 1);
        @(negedge clk);
        chk("R12", "done width", done, 0);
        repeat (3) @(negedge clk);
        chk("R12", "h_step held", h_step, e[5]);
        chk("R12", "v_step held", v_step, e[6]);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        chk("R12", "reset done", done, 0);
        chk("R1", "reset bypass", bypass, 0);
        chk("R2", "reset linear", linear, 0);
        chk("R4", "reset h_step", h_step, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b0);
        end

        // R13: start pulse during a running-average computation is ignored
        run(1920, 1080, 320, 200, 1'b1);
        // R13: start pulse during a polyphase computation is ignored
        run(1920, 1080, 1280, 720, 1'b1);
        // Back-to-back: bypass right after a full computation clears all values (R1)
        run(1920, 1080, 320, 200, 1'b0);
        run(800, 600, 800, 600, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule